// File: doc/BRIEF.md
# Instruction Prefetch Stream Buffer

This block sits between a small instruction cache and a slower memory port. It carries out next-block instruction prefetch. When the fetch side reports a miss on block address B, the block asks memory for B and delivers the returned block through the cache fill port. It then asks memory for block B+1 on its own initiative. That speculative block does not go into the cache. It waits in a one-entry side buffer, which keeps the block data, its block address as a tag, and a valid flag.

A later miss on the buffered address is answered straight from the buffer, with no memory access, and a fresh prefetch of the following block begins. A miss on any other address empties the buffer. The memory port carries one request at a time, and demand misses take precedence over prefetches. A miss that arrives while its own block is already being prefetched waits for that in-flight response instead of asking memory a second time. Prefetching only changes timing: the fetch side always receives the data of the block it asked for.

Top module: `ipf_stream_buf`

## Requirements
- R1: A miss (`lk_valid` with `lk_ready`) whose block is not in the buffer drives `mem_req` with `mem_blk` equal to the miss address. The memory response is then offered on the fill port, with `fill_blk` equal to the miss address and `fill_data` equal to the returned data. `lk_done` is high in the handshake cycle, and `lk_data` equals that data.
- R2: In the cycle after every fill handshake, `mem_req` is high with `mem_blk` set to the filled block address plus one.
- R3: A completed prefetch that no miss is waiting for produces no fill. Its data stays in the side buffer.
- R4: A miss on the buffered, valid block address is answered from the buffer with no memory request, and `lk_from_buf` is 1 during that fill.
- R5: A miss on any other address empties the buffer, so a later miss on the old buffered address goes to memory.
- R6: At most one memory request is outstanding at a time. A miss that arrives while a prefetch request has not yet been granted withdraws that prefetch and requests the demand block instead.
- R7: A miss on a different block that arrives while a prefetch is outstanding waits for the prefetch response. That response is discarded and is not buffered. The demand block is then requested, and the delivered data is the demand block's.
- R8: A miss on the block that is being prefetched issues no second request. The prefetch response is filled as the demand block.
- R9: While `fill_ready` is low, `fill_valid`, `fill_blk` and `fill_data` hold steady.
- R10: `lk_ready` is low from the acceptance of a miss until its fill completes, except during a prefetch that no miss is waiting on.
- R11: The successor block address wraps from all ones to zero.
- R12: After reset there is no request and no fill, `lk_ready` is high, and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Fetch side reports a cache miss |
| lk_blk | input | BAW | Block address of the miss |
| lk_ready | output | 1 | Miss can be accepted this cycle |
| lk_done | output | 1 | Requested block delivered this cycle |
| lk_data | output | DW | Block data for the fetch side |
| lk_from_buf | output | 1 | Delivered block came from the side buffer |
| fill_valid | output | 1 | Fill offer to the cache |
| fill_ready | input | 1 | Cache accepts the fill |
| fill_blk | output | BAW | Block address being filled |
| fill_data | output | DW | Block data being filled |
| mem_req | output | 1 | Memory request |
| mem_gnt | input | 1 | Memory accepts the request |
| mem_blk | output | BAW | Requested block address |
| mem_rvalid | input | 1 | Memory response valid |
| mem_rdata | input | DW | Memory response data |

## Verification
Two events can land on the same clock edge: a new miss and the grant of the speculative request for the following block. The bench provokes this by presenting the next miss at the moment the previous fill completes. The miss is then accepted in the very cycle the prefetch is granted. It is tried once with the miss naming the prefetched block and once with a different block. The outcome is judged at the ports from the logged request addresses: the request sequence must be a single request, or prefetch then demand. The delivered data must match the block that was asked for.

// File: rtl/ipf_pkg.sv
package ipf_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DREQ,
    S_DWAIT,
    S_FILL,
    S_PREQ,
    S_PWAIT
  } seq_state_e;

  // successor block address; caller truncates to its own width (wraps)
  function automatic logic [31:0] blk_succ(input logic [31:0] b);
    return b + 32'd1;
  endfunction

endpackage

// File: rtl/ipf_sbuf.sv
module ipf_sbuf #(
  parameter int BAW = 10,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           wr,
  input  logic [BAW-1:0] wtag,
  input  logic [DW-1:0]  wdata,
  input  logic [BAW-1:0] look_blk,
  output logic           match,
  output logic [DW-1:0]  rdata
);

  logic           vld_q;
  logic [BAW-1:0] tag_q;
  logic [DW-1:0]  dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      tag_q <= '0;
      dat_q <= '0;
    end else if (wr) begin
      vld_q <= 1'b1;
      tag_q <= wtag;
      dat_q <= wdata;
    end else if (clr) begin
      vld_q <= 1'b0;
    end
  end

  assign match = vld_q && (tag_q == look_blk);
  assign rdata = dat_q;

endmodule

// File: rtl/ipf_seq.sv
module ipf_seq
  import ipf_pkg::*;
#(
  parameter int BAW = 10,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           lk_valid,
  input  logic [BAW-1:0] lk_blk,
  output logic           lk_ready,
  input  logic           sb_match,
  input  logic [DW-1:0]  sb_data,
  output logic           sb_clr,
  output logic           sb_wr,
  output logic [BAW-1:0] sb_wtag,
  output logic [DW-1:0]  sb_wdata,
  output logic           fill_valid,
  input  logic           fill_ready,
  output logic [BAW-1:0] fill_blk,
  output logic [DW-1:0]  fill_data,
  output logic           fill_from_buf,
  output logic           mem_req,
  input  logic           mem_gnt,
  output logic [BAW-1:0] mem_blk,
  input  logic           mem_rvalid,
  input  logic [DW-1:0]  mem_rdata,
  output logic           ev_accept,
  output logic           ev_sb_hit,
  output logic           ev_pf_drop
);

  seq_state_e     st_q;
  logic [BAW-1:0] tgt_q, dem_q, fblk_q;
  logic [DW-1:0]  fdat_q;
  logic           pend_q, join_q, fbuf_q;

  logic in_pf, pf_rsp, pend_now, join_now;

  assign in_pf     = (st_q == S_PREQ) || (st_q == S_PWAIT);
  assign lk_ready  = (st_q == S_IDLE) || (in_pf && !pend_q);
  assign ev_accept = lk_valid && lk_ready;
  assign ev_sb_hit = ev_accept && (st_q == S_IDLE) && sb_match;

  assign pf_rsp    = (st_q == S_PWAIT) && mem_rvalid;
  assign pend_now  = pend_q || (ev_accept && in_pf);
  assign join_now  = pend_q ? join_q : (lk_blk == tgt_q);
  assign ev_pf_drop = pf_rsp && pend_now && !join_now;

  assign sb_clr   = ev_accept;
  assign sb_wr    = pf_rsp && !pend_now;
  assign sb_wtag  = tgt_q;
  assign sb_wdata = mem_rdata;

  assign mem_req = (st_q == S_DREQ) || (st_q == S_PREQ);
  assign mem_blk = tgt_q;

  assign fill_valid    = (st_q == S_FILL);
  assign fill_blk      = fblk_q;
  assign fill_data     = fdat_q;
  assign fill_from_buf = fbuf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      tgt_q  <= '0;
      dem_q  <= '0;
      fblk_q <= '0;
      fdat_q <= '0;
      pend_q <= 1'b0;
      join_q <= 1'b0;
      fbuf_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (ev_accept) begin
          if (sb_match) begin
            st_q   <= S_FILL;
            fblk_q <= lk_blk;
            fdat_q <= sb_data;
            fbuf_q <= 1'b1;
          end else begin
            st_q  <= S_DREQ;
            tgt_q <= lk_blk;
          end
        end
        S_DREQ: if (mem_gnt) st_q <= S_DWAIT;
        S_DWAIT: if (mem_rvalid) begin
          st_q   <= S_FILL;
          fblk_q <= tgt_q;
          fdat_q <= mem_rdata;
          fbuf_q <= 1'b0;
        end
        S_FILL: if (fill_ready) begin
          st_q  <= S_PREQ;
          tgt_q <= BAW'(blk_succ(32'(fblk_q)));
        end
        S_PREQ: begin
          if (ev_accept && !mem_gnt) begin
            st_q  <= S_DREQ;          // prefetch withdrawn, demand first
            tgt_q <= lk_blk;
          end else if (mem_gnt) begin
            st_q <= S_PWAIT;
            if (ev_accept) begin
              pend_q <= 1'b1;
              join_q <= (lk_blk == tgt_q);
              dem_q  <= lk_blk;
            end
          end
        end
        S_PWAIT: begin
          if (pf_rsp) begin
            pend_q <= 1'b0;
            if (pend_now && join_now) begin
              st_q   <= S_FILL;
              fblk_q <= tgt_q;
              fdat_q <= mem_rdata;
              fbuf_q <= 1'b0;
            end else if (pend_now) begin
              st_q  <= S_DREQ;
              tgt_q <= pend_q ? dem_q : lk_blk;
            end else begin
              st_q <= S_IDLE;
            end
          end else if (ev_accept) begin
            pend_q <= 1'b1;
            join_q <= (lk_blk == tgt_q);
            dem_q  <= lk_blk;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ipf_stream_buf.sv
module ipf_stream_buf #(
  parameter int BAW = 10,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           lk_valid,
  input  logic [BAW-1:0] lk_blk,
  output logic           lk_ready,
  output logic           lk_done,
  output logic [DW-1:0]  lk_data,
  output logic           lk_from_buf,
  output logic           fill_valid,
  input  logic           fill_ready,
  output logic [BAW-1:0] fill_blk,
  output logic [DW-1:0]  fill_data,
  output logic           mem_req,
  input  logic           mem_gnt,
  output logic [BAW-1:0] mem_blk,
  input  logic           mem_rvalid,
  input  logic [DW-1:0]  mem_rdata
);

  logic           sb_match, sb_clr, sb_wr;
  logic [DW-1:0]  sb_data, sb_wdata;
  logic [BAW-1:0] sb_wtag;
  logic           ev_accept, ev_sb_hit, ev_pf_drop;

  ipf_sbuf #(.BAW(BAW), .DW(DW)) u_sbuf (
    .clk(clk), .rst_n(rst_n), .clr(sb_clr), .wr(sb_wr),
    .wtag(sb_wtag), .wdata(sb_wdata), .look_blk(lk_blk),
    .match(sb_match), .rdata(sb_data)
  );

  ipf_seq #(.BAW(BAW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_blk(lk_blk), .lk_ready(lk_ready),
    .sb_match(sb_match), .sb_data(sb_data), .sb_clr(sb_clr),
    .sb_wr(sb_wr), .sb_wtag(sb_wtag), .sb_wdata(sb_wdata),
    .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_blk(fill_blk), .fill_data(fill_data), .fill_from_buf(lk_from_buf),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_blk(mem_blk),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ev_accept(ev_accept), .ev_sb_hit(ev_sb_hit), .ev_pf_drop(ev_pf_drop)
  );

  assign lk_done = fill_valid && fill_ready;
  assign lk_data = fill_data;

endmodule

// File: rtl/ipf_stream_buf_chk.sv
module ipf_stream_buf_chk
  import ipf_pkg::*;
#(
  parameter int BAW = 10,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           fill_valid,
  input logic           fill_ready,
  input logic [BAW-1:0] fill_blk,
  input logic [DW-1:0]  fill_data,
  input logic           lk_from_buf,
  input logic           mem_req,
  input logic           mem_gnt,
  input logic [BAW-1:0] mem_blk,
  input logic           mem_rvalid,
  input logic           ev_sb_hit,
  input logic           sb_wr
);

  logic [1:0] outst;
  always_ff @(posedge clk) begin
    if (!rst_n) outst <= '0;
    else outst <= outst + 2'(mem_req && mem_gnt) - 2'(mem_rvalid);
  end

  p_single_outstanding_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> outst == 2'd0);

  p_no_orphan_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> outst == 2'd1);

  p_buf_hit_no_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sb_hit |=> fill_valid && lk_from_buf && !mem_req);

  p_fill_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && !fill_ready |=> fill_valid && $stable(fill_data) && $stable(fill_blk));

  p_next_prefetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && fill_ready |=> mem_req && mem_blk == BAW'(blk_succ(32'($past(fill_blk)))));

  p_prefetch_not_filled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sb_wr |=> !fill_valid);

endmodule

bind ipf_stream_buf ipf_stream_buf_chk #(.BAW(BAW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_ready(fill_ready),
  .fill_blk(fill_blk), .fill_data(fill_data), .lk_from_buf(lk_from_buf),
  .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_blk(mem_blk),
  .mem_rvalid(mem_rvalid), .ev_sb_hit(ev_sb_hit), .sb_wr(sb_wr)
);

// File: tb/ipf_stream_buf_test.sv
module ipf_stream_buf_test;

  localparam int BAW = 10;
  localparam int DW  = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           lk_valid = 1'b0;
  logic [BAW-1:0] lk_blk = '0;
  logic           lk_ready, lk_done, lk_from_buf;
  logic [DW-1:0]  lk_data;
  logic           fill_valid;
  logic           fill_ready = 1'b1;
  logic [BAW-1:0] fill_blk;
  logic [DW-1:0]  fill_data;
  logic           mem_req, mem_gnt;
  logic [BAW-1:0] mem_blk;
  logic           mem_rvalid;
  logic [DW-1:0]  mem_rdata;

  logic gnt_en = 1'b1;
  int   lat = 2;
  assign mem_gnt = gnt_en;

  always #5 clk = ~clk;

  ipf_stream_buf #(.BAW(BAW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_blk(lk_blk),
    .lk_ready(lk_ready), .lk_done(lk_done), .lk_data(lk_data),
    .lk_from_buf(lk_from_buf), .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_blk(fill_blk), .fill_data(fill_data), .mem_req(mem_req),
    .mem_gnt(mem_gnt), .mem_blk(mem_blk), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [DW-1:0] mdata(input logic [BAW-1:0] b);
    return {6'h2B, b, 6'h15, ~b};
  endfunction

  // memory model and monitors
  logic           busy;
  int             cnt;
  logic [BAW-1:0] pblk;
  int             req_cnt = 0;
  int             fill_cnt = 0;
  logic [BAW-1:0] req_log [0:63];

  always @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; mem_rvalid <= 1'b0; mem_rdata <= '0; cnt <= 0; pblk <= '0;
    end else begin
      mem_rvalid <= 1'b0;
      if (busy) begin
        if (cnt == 0) begin
          mem_rvalid <= 1'b1; mem_rdata <= mdata(pblk); busy <= 1'b0;
        end else cnt <= cnt - 1;
      end
      if (mem_req && mem_gnt) begin
        busy <= 1'b1; cnt <= lat; pblk <= mem_blk;
        req_log[req_cnt[5:0]] <= mem_blk;
        req_cnt <= req_cnt + 1;
      end
      if (fill_valid && fill_ready) fill_cnt <= fill_cnt + 1;
    end
  end

  int n_run = 0;
  int n_fail = 0;
  logic [DW-1:0] got_data;
  logic          got_buf;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input logic [BAW-1:0] b);
    lk_valid = 1'b1; lk_blk = b;
    while (!lk_ready) @(negedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!(fill_valid && fill_ready)) @(negedge clk);
    got_data = lk_data;
    got_buf  = lk_from_buf;
  endtask

  task automatic lookup(input logic [BAW-1:0] b);
    issue(b);
    wait_done();
  endtask

  task automatic t_reset();
    chk(!fill_valid && !mem_req, "R12 idle outputs", {fill_valid, mem_req}, 0);
    chk(lk_ready, "R12 ready after reset", lk_ready, 1);
  endtask

  task automatic t_cold();
    int base, fb;
    base = req_cnt; fb = fill_cnt;
    issue(10'h010);
    chk(!lk_ready, "R10 not ready while demand pending", lk_ready, 0);
    wait_done();
    chk(got_data == mdata(10'h010), "R1 demand data", got_data, mdata(10'h010));
    chk(!got_buf, "R12 first miss goes to memory", got_buf, 0);
    chk(fill_blk == 10'h010, "R1 fill address", fill_blk, 10'h010);
    settle(12);
    chk(req_cnt - base == 2, "R2 demand plus prefetch", req_cnt - base, 2);
    chk(req_log[(base+1)%64] == 10'h011, "R2 prefetch address", req_log[(base+1)%64], 10'h011);
    chk(fill_cnt - fb == 1, "R3 prefetch not filled", fill_cnt - fb, 1);
  endtask

  task automatic t_buf_hit();
    int base;
    base = req_cnt;
    lookup(10'h011);
    chk(got_buf, "R4 served from buffer", got_buf, 1);
    chk(got_data == mdata(10'h011), "R4 buffer data", got_data, mdata(10'h011));
    chk(req_cnt == base, "R4 no memory access", req_cnt - base, 0);
    settle(12);
    chk(req_log[base%64] == 10'h012, "R2 prefetch after buffer hit", req_log[base%64], 10'h012);
  endtask

  task automatic t_inval();
    lookup(10'h040);
    chk(!got_buf, "R5 mismatch goes to memory", got_buf, 0);
    settle(12);
    lookup(10'h012);
    chk(!got_buf, "R5 old buffer entry dropped", got_buf, 0);
    chk(got_data == mdata(10'h012), "R5 data", got_data, mdata(10'h012));
    settle(12);
  endtask

  task automatic t_preempt();
    int base;
    lookup(10'h020);
    gnt_en = 1'b0;
    @(negedge clk);
    chk(mem_req && mem_blk == 10'h021, "R2 prefetch offered", mem_blk, 10'h021);
    lk_valid = 1'b1; lk_blk = 10'h050;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(mem_req && mem_blk == 10'h050, "R6 demand preempts prefetch", mem_blk, 10'h050);
    base = req_cnt;
    gnt_en = 1'b1;
    wait_done();
    chk(got_data == mdata(10'h050), "R6 demand data", got_data, mdata(10'h050));
    chk(req_log[base%64] == 10'h050, "R6 withdrawn prefetch never sent", req_log[base%64], 10'h050);
    settle(12);
  endtask

  task automatic t_collide_other();
    int base;
    lookup(10'h030);
    base = req_cnt;
    issue(10'h060);
    wait_done();
    chk(got_data == mdata(10'h060), "R7 collision data", got_data, mdata(10'h060));
    chk(req_log[base%64] == 10'h031 && req_log[(base+1)%64] == 10'h060,
        "R7 prefetch then demand", req_log[(base+1)%64], 10'h060);
    settle(12);
  endtask

  task automatic t_collide_join();
    int base;
    lookup(10'h070);
    base = req_cnt;
    issue(10'h071);
    wait_done();
    chk(got_data == mdata(10'h071) && !got_buf, "R8 joined data", got_data, mdata(10'h071));
    settle(12);
    chk(req_cnt - base == 2, "R8 no duplicate request", req_cnt - base, 2);
    chk(req_log[(base+1)%64] == 10'h072, "R8 next prefetch", req_log[(base+1)%64], 10'h072);
  endtask

  task automatic t_late();
    int base;
    lat = 6;
    lookup(10'h080);
    base = req_cnt;
    settle(3);
    issue(10'h081);
    wait_done();
    chk(got_data == mdata(10'h081), "R8 late join data", got_data, mdata(10'h081));
    settle(16);
    chk(req_cnt - base == 2, "R8 late join single request", req_cnt - base, 2);
    lookup(10'h090);
    base = req_cnt;
    settle(3);
    issue(10'h0A0);
    wait_done();
    chk(got_data == mdata(10'h0A0), "R7 wait then demand data", got_data, mdata(10'h0A0));
    chk(req_log[base%64] == 10'h091 && req_log[(base+1)%64] == 10'h0A0,
        "R7 order", req_log[(base+1)%64], 10'h0A0);
    settle(16);
    lookup(10'h091);
    chk(!got_buf, "R7 discarded prefetch not buffered", got_buf, 0);
    settle(16);
    lat = 2;
  endtask

  task automatic t_stall();
    logic [DW-1:0] cap;
    fill_ready = 1'b0;
    issue(10'h150);
    while (!fill_valid) @(negedge clk);
    cap = fill_data;
    repeat (3) begin
      @(negedge clk);
      chk(fill_valid && fill_data == cap && fill_blk == 10'h150 && !lk_done,
          "R9 fill held", fill_data, cap);
    end
    chk(cap == mdata(10'h150), "R9 held data", cap, mdata(10'h150));
    fill_ready = 1'b1;
    wait_done();
    settle(12);
  endtask

  task automatic t_wrap();
    int base;
    lookup(10'h3FF);
    base = req_cnt;
    settle(12);
    chk(req_log[base%64] == 10'h000, "R11 successor wraps", req_log[base%64], 0);
    lookup(10'h000);
    chk(got_buf && got_data == mdata(10'h000), "R11 wrapped block from buffer", got_buf, 1);
    settle(12);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_run++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cold();
    t_buf_hit();
    t_inval();
    t_preempt();
    t_collide_other();
    t_collide_join();
    t_late();
    t_stall();
    t_wrap();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule